// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block is a small SPI master that software drives through a byte-wide register window. Software first loads an opcode, a packed transmit/receive byte-count register and the payload bytes. The payload goes through a data port into an 8-slot ring buffer. Software then sets a start bit. The engine pulls chip select low and sends the opcode, which never enters the ring. It then streams ring slots out on MOSI, starting at slot 0. Each byte sampled on MISO during a slot's shift is written back into that same slot. When the last byte has been exchanged, the engine raises chip select and clears the start bit.

The ring is never cleared. A response therefore sits in the slots that follow the transmitted payload. To collect it, software rewinds the data-port pointer, reads past the bytes it sent and then reads the response. The engine walks the ring with its own index, so the pointer that software uses stays where software left it. The serial link uses SPI mode 0 with MSB first. The serial clock is the system clock divided by a power of two set by a parameter.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, every readable register returns zero: opcode, counts, control, pointer and all eight ring slots.
- R2: Each transaction sends the opcode byte first. It then sends the ring content of slots 0, 1, 2 and so on, with one byte per slot.
- R3: In the count register at offset 0x01, bits 3:0 give the transmit byte count and bits 7:4 give the receive byte count. Any value above 8 is treated as 8. One chip-select window carries exactly 1 + transmit + receive bytes.
- R4: Writing 1 to bit 0 of offset 0x02 starts a transaction. That bit reads 1 until the transaction ends and 0 after it. Chip select is high whenever the bit is 0.
- R5: Writing 1 to bit 4 of offset 0x02 sets the data-port pointer to 0. This bit always reads back as 0.
- R6: Each read or write at offset 0x0C accesses the slot under the pointer and then advances the pointer by one, modulo 8. Offset 0x0D returns the pointer in bits 2:0.
- R7: Wire byte i after the opcode (i from 0) goes out from slot i mod 8. The byte received during that shift overwrites that same slot. No other slot changes.
- R8: With a transmit count of 0, all requested receive bytes are captured, including the last one.
- R9: While the start bit is 1, writes to offsets 0x00, 0x01 and 0x0C have no effect. A data-port write in that state also leaves the pointer unmoved.
- R10: The serial link is mode 0, MSB first. The clock idles low whenever chip select is high, and MOSI does not change on a rising edge. Consecutive rising edges within a byte are 2^(DIV_LOG2+1) system clocks apart.
- R11: A transaction leaves the software pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench targets four corner cases:
- A zero transmit count, where a design that drops the final response byte leaves the last slot stale.
- A full 8+8 transfer whose index wraps around the ring, where the second lap must send the bytes received on the first lap. A design that indexes from a snapshot, or that clears slots, sends the wrong bytes.
- Counts above eight, where a design without clamping overruns the chip-select window.
- Writes made during a transaction, where a design that fails to block them corrupts the opcode or moves the software pointer, and the readback after the transaction shows it.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   localparam int REG_AW = 4;
   localparam logic [REG_AW-1:0] OFS_OPCODE = 4'h0;
   localparam logic [REG_AW-1:0] OFS_COUNTS = 4'h1;
   localparam logic [REG_AW-1:0] OFS_CTRL   = 4'h2;
   localparam logic [REG_AW-1:0] OFS_DATA   = 4'hC;
   localparam logic [REG_AW-1:0] OFS_PTR    = 4'hD;
   localparam int CTRL_GO_BIT   = 0;
   localparam int CTRL_PRST_BIT = 4;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_OPCODE,
      SQ_LOAD,
      SQ_SHIFT,
      SQ_END
   } seq_state_e;
endpackage

// File: rtl/spi_cmd_ring.sv
module spi_cmd_ring #(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ptr_clr,
   input  logic          sw_wr,
   input  logic          sw_rd,
   input  logic [DW-1:0] sw_wdata,
   output logic [DW-1:0] sw_rdata,
   output logic [PW-1:0] sw_ptr,
   input  logic [PW-1:0] eng_idx,
   input  logic          eng_we,
   input  logic [DW-1:0] eng_wdata,
   output logic [DW-1:0] eng_rdata
);
   logic [DW-1:0] mem_q [DEPTH];
   logic [PW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (ptr_clr) begin
         ptr_q <= '0;
      end else if (sw_wr || sw_rd) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (eng_we) begin
         mem_q[eng_idx] <= eng_wdata;
      end else if (sw_wr) begin
         mem_q[ptr_q] <= sw_wdata;
      end
   end

   assign sw_rdata  = mem_q[ptr_q];
   assign eng_rdata = mem_q[eng_idx];
   assign sw_ptr    = ptr_q;
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
   parameter int DW       = 8,
   parameter int DIV_LOG2 = 1,
   localparam int BC_W    = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] tx_byte,
   input  logic          miso,
   output logic          sclk,
   output logic          mosi,
   output logic          done,
   output logic [DW-1:0] rx_byte
);
   logic            active_q;
   logic            sclk_q;
   logic            done_q;
   logic [DW-1:0]   sh_q;
   logic [DW-1:0]   rx_q;
   logic [BC_W-1:0] bit_q;
   logic            tick;

   generate
      if (DIV_LOG2 == 0) begin : g_nodiv
         assign tick = active_q;
      end else begin : g_div
         logic [DIV_LOG2-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                div_q <= '0;
            else if (start || !active_q) div_q <= '0;
            else                       div_q <= div_q + 1'b1;
         end
         assign tick = active_q && (&div_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sclk_q   <= 1'b0;
         done_q   <= 1'b0;
         sh_q     <= '0;
         rx_q     <= '0;
         bit_q    <= '0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            active_q <= 1'b1;
            sh_q     <= tx_byte;
            bit_q    <= '0;
            sclk_q   <= 1'b0;
         end else if (tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rx_q   <= {rx_q[DW-2:0], miso};
            end else begin
               sclk_q <= 1'b0;
               sh_q   <= {sh_q[DW-2:0], 1'b0};
               if (bit_q == BC_W'(DW - 1)) begin
                  active_q <= 1'b0;
                  done_q   <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
               end
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign mosi    = sh_q[DW-1];
   assign done    = done_q;
   assign rx_byte = rx_q;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
   import spi_cmd_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int DW    = 8,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(2 * DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] opcode,
   input  logic [3:0]    tx_cnt,
   input  logic [3:0]    rx_cnt,
   input  logic          sh_done,
   input  logic [DW-1:0] sh_rx,
   input  logic [DW-1:0] ring_rdata,
   output logic          sh_start,
   output logic [DW-1:0] sh_tx,
   output logic          cs_n,
   output logic [PW-1:0] ring_idx,
   output logic          ring_we,
   output logic [DW-1:0] ring_wdata,
   output logic          fin
);
   seq_state_e    state_q;
   logic [CW-1:0] remain_q;
   logic [PW-1:0] idx_q;
   logic          cs_n_q;

   function automatic logic [CW-1:0] clamp_cnt(input logic [3:0] c);
      if (int'(c) > DEPTH) return CW'(DEPTH);
      return CW'(c);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         remain_q <= '0;
         idx_q    <= '0;
         cs_n_q   <= 1'b1;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (go) begin
               cs_n_q   <= 1'b0;
               idx_q    <= '0;
               remain_q <= clamp_cnt(tx_cnt) + clamp_cnt(rx_cnt);
               state_q  <= SQ_OPCODE;
            end
            SQ_OPCODE: if (sh_done) begin
               state_q <= (remain_q == '0) ? SQ_END : SQ_LOAD;
            end
            SQ_LOAD: state_q <= SQ_SHIFT;
            SQ_SHIFT: if (sh_done) begin
               idx_q    <= idx_q + 1'b1;
               remain_q <= remain_q - 1'b1;
               state_q  <= (remain_q == CW'(1)) ? SQ_END : SQ_LOAD;
            end
            SQ_END: begin
               cs_n_q  <= 1'b1;
               state_q <= SQ_IDLE;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign sh_start   = (state_q == SQ_IDLE && go) || (state_q == SQ_LOAD);
   assign sh_tx      = (state_q == SQ_LOAD) ? ring_rdata : opcode;
   assign ring_idx   = idx_q;
   assign ring_we    = (state_q == SQ_SHIFT) && sh_done;
   assign ring_wdata = sh_rx;
   assign cs_n       = cs_n_q;
   assign fin        = (state_q == SQ_END);
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_cmd_pkg::*;
#(
   parameter int FIFO_DEPTH = 8,
   parameter int DIV_LOG2   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] bus_addr,
   input  logic       bus_wr,
   input  logic       bus_rd,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       spi_sclk,
   output logic       spi_cs_n,
   output logic       spi_mosi,
   input  logic       spi_miso
);
   localparam int DW = 8;
   localparam int PW = $clog2(FIFO_DEPTH);

   generate
      if (FIFO_DEPTH < 2 || FIFO_DEPTH > 16 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a power of two between 2 and 16");
      end
      if (DIV_LOG2 < 0 || DIV_LOG2 > 8) begin : g_bad_div
         $error("DIV_LOG2 must lie in 0..8");
      end
   endgenerate

   logic [DW-1:0] opc_q;
   logic [DW-1:0] cnt_q;
   logic          exec_q;
   logic [DW-1:0] rdata_q;

   logic          go, fin, ptr_clr, sw_wr, sw_rd;
   logic [DW-1:0] sw_rdata, eng_rdata, ring_wdata, sh_tx, sh_rx;
   logic [PW-1:0] sw_ptr, ring_idx;
   logic [3:0]    ptr_ext;
   logic          ring_we, sh_start, sh_done;

   assign go      = bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_GO_BIT] && !exec_q;
   assign ptr_clr = bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_PRST_BIT];
   assign sw_wr   = bus_wr && bus_addr == OFS_DATA && !exec_q;
   assign sw_rd   = bus_rd && bus_addr == OFS_DATA;
   assign ptr_ext = 4'(sw_ptr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q  <= '0;
         cnt_q  <= '0;
         exec_q <= 1'b0;
      end else begin
         if (bus_wr && !exec_q && bus_addr == OFS_OPCODE) opc_q <= bus_wdata;
         if (bus_wr && !exec_q && bus_addr == OFS_COUNTS) cnt_q <= bus_wdata;
         if (fin)     exec_q <= 1'b0;
         else if (go) exec_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         unique case (bus_addr)
            OFS_OPCODE: rdata_q <= opc_q;
            OFS_COUNTS: rdata_q <= cnt_q;
            OFS_CTRL:   rdata_q <= {7'b0, exec_q};
            OFS_DATA:   rdata_q <= sw_rdata;
            OFS_PTR:    rdata_q <= {4'b0, ptr_ext};
            default:    rdata_q <= '0;
         endcase
      end
   end
   assign bus_rdata = rdata_q;

   spi_cmd_ring #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_ring (
      .clk(clk), .rst_n(rst_n), .ptr_clr(ptr_clr), .sw_wr(sw_wr), .sw_rd(sw_rd),
      .sw_wdata(bus_wdata), .sw_rdata(sw_rdata), .sw_ptr(sw_ptr),
      .eng_idx(ring_idx), .eng_we(ring_we), .eng_wdata(ring_wdata), .eng_rdata(eng_rdata)
   );

   spi_cmd_seq #(.DEPTH(FIFO_DEPTH), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .opcode(opc_q),
      .tx_cnt(cnt_q[3:0]), .rx_cnt(cnt_q[7:4]),
      .sh_done(sh_done), .sh_rx(sh_rx), .ring_rdata(eng_rdata),
      .sh_start(sh_start), .sh_tx(sh_tx), .cs_n(spi_cs_n),
      .ring_idx(ring_idx), .ring_we(ring_we), .ring_wdata(ring_wdata), .fin(fin)
   );

   spi_cmd_shift #(.DW(DW), .DIV_LOG2(DIV_LOG2)) u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
      .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx_byte(sh_rx)
   );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
   import spi_cmd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] bus_addr,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic [7:0] bus_wdata,
   input logic       spi_sclk,
   input logic       spi_cs_n,
   input logic       spi_mosi,
   input logic       exec_q,
   input logic [7:0] opc_q,
   input logic [7:0] cnt_q,
   input logic [3:0] ptr_ext
);
   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_q |-> spi_cs_n); // R4
   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk); // R10
   AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_sclk) |-> $stable(spi_mosi)); // R10
   AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_CTRL && bus_wdata[CTRL_PRST_BIT]) |=> ptr_ext == 4'd0); // R5
   AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == OFS_DATA) |=> ptr_ext != $past(ptr_ext)); // R6
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      exec_q |=> ($stable(opc_q) && $stable(cnt_q))); // R9
   AST_PTR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_q && !bus_rd && !(bus_wr && bus_addr == OFS_CTRL)) |=> $stable(ptr_ext)); // R11
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_wdata(bus_wdata), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
   .exec_q(exec_q), .opc_q(opc_q), .cnt_q(cnt_q), .ptr_ext(ptr_ext)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit model_busy = 0;
   logic [7:0] m_ring [8];
   int m_ptr = 0;
   int seed = 0;
   logic [7:0] wire_q [$];

   always #2.5 clk = ~clk;

   spi_cmd_engine u_spi_cmd_engine (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
      .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   function automatic logic [7:0] resp_byte(input int k);
      return 8'((k * 29 + seed * 7 + 3) & 255);
   endfunction

   // Device model: drive MISO, shift on falling edges
   int mb = 0;
   int mk = 0;
   always @(posedge spi_cs_n or negedge spi_sclk) begin
      if (spi_cs_n) begin
         mb = 0; mk = 0;
      end else begin
         mb = mb + 1;
         if (mb == 8) begin mb = 0; mk = mk + 1; end
      end
   end
   logic [7:0] cur_resp;
   always @* cur_resp = resp_byte(mk);
   assign spi_miso = cur_resp[3'(7 - mb)];

   // Device model: capture MOSI on rising edges, check rise spacing
   int cap_n = 0;
   logic [7:0] cap_sh = '0;
   realtime last_rise = 0;
   always @(posedge spi_sclk or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         cap_n = 0;
      end else begin
         if (cap_n != 0) begin
            tests++;
            if ($realtime - last_rise != 20.0) begin
               fails++;
               $display("FAIL R10: sclk rise spacing actual %0t expected 20ns", $realtime - last_rise);
            end
         end
         last_rise = $realtime;
         cap_sh = {cap_sh[6:0], spi_mosi};
         cap_n = cap_n + 1;
         if (cap_n == 8) begin wire_q.push_back(cap_sh); cap_n = 0; end
      end
   end

   // Per-clock reference comparison of link idle state
   always @(negedge clk) begin
      if (rst_n) begin
         tests++;
         if (!model_busy && !spi_cs_n) begin
            fails++;
            $display("FAIL R4: cs_n actual 0 expected 1 while idle");
         end
         if (spi_cs_n && spi_sclk) begin
            fails++;
            $display("FAIL R10: sclk actual 1 expected 0 with cs_n high");
         end
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bwr(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic brd(input logic [3:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic sw_write(input logic [7:0] d);
      bwr(4'hC, d);
      m_ring[m_ptr] = d;
      m_ptr = (m_ptr + 1) % 8;
   endtask

   task automatic rewind();
      bwr(4'h2, 8'h10);
      m_ptr = 0;
   endtask

   task automatic run_txn(input logic [7:0] op, input int t_raw, input int r_raw, input int sd);
      logic [7:0] rd;
      int t, r, n, guard;
      logic [7:0] exp_wire [$];
      seed = sd;
      t = (t_raw > 8) ? 8 : t_raw;
      r = (r_raw > 8) ? 8 : r_raw;
      rewind();
      for (int i = 0; i < t; i++) sw_write(8'((sd * 13 + i * 37 + 5) & 255));
      bwr(4'h0, op);
      bwr(4'h1, {4'(r_raw), 4'(t_raw)});
      rewind();
      wire_q.delete();
      model_busy = 1;
      bwr(4'h2, 8'h01);
      brd(4'h2, rd); chk("R4 start bit busy", int'(rd), 1);
      bwr(4'h0, 8'hEE);
      bwr(4'h1, 8'h00);
      bwr(4'hC, 8'h5A);
      brd(4'hD, rd); chk("R9 ptr unmoved by blocked data write", int'(rd), 0);
      guard = 0;
      do begin brd(4'h2, rd); guard++; end while (rd[0] && guard < 2000);
      chk("R4 start bit cleared", int'(rd[0]), 0);
      model_busy = 0;
      exp_wire.push_back(op);
      for (int i = 0; i < t + r; i++) begin
         exp_wire.push_back(m_ring[i % 8]);
         m_ring[i % 8] = resp_byte(i + 1);
      end
      n = wire_q.size();
      chk("R3 bytes in cs window", n, exp_wire.size());
      if (n == exp_wire.size()) begin
         chk("R2 opcode first", int'(wire_q[0]), int'(op));
         for (int i = 1; i < n; i++) chk("R7 wire byte from slot", int'(wire_q[i]), int'(exp_wire[i]));
      end
      brd(4'h0, rd); chk("R9 opcode kept", int'(rd), int'(op));
      brd(4'h1, rd); chk("R9 counts kept", int'(rd), int'({4'(r_raw), 4'(t_raw)}));
      brd(4'hD, rd); chk("R11 ptr unchanged by engine", int'(rd), m_ptr);
      for (int i = 0; i < 8; i++) begin
         brd(4'hC, rd);
         chk((t == 0) ? "R8 slot after rx-only" : "R7 slot content", int'(rd), int'(m_ring[m_ptr]));
         m_ptr = (m_ptr + 1) % 8;
      end
      brd(4'hD, rd); chk("R6 ptr wrapped", int'(rd), m_ptr);
   endtask

   initial begin
      logic [7:0] rd;
      for (int i = 0; i < 8; i++) m_ring[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      brd(4'h0, rd); chk("R1 opcode reset", int'(rd), 0);
      brd(4'h1, rd); chk("R1 counts reset", int'(rd), 0);
      brd(4'h2, rd); chk("R1 control reset", int'(rd), 0);
      brd(4'hD, rd); chk("R1 ptr reset", int'(rd), 0);
      for (int i = 0; i < 8; i++) begin
         brd(4'hC, rd); chk("R1 slot reset", int'(rd), 0);
      end
      brd(4'hD, rd); chk("R6 ptr after 8 reads", int'(rd), 0);
      for (int i = 0; i < 10; i++) sw_write(8'(8'h40 + i));
      brd(4'hD, rd); chk("R6 ptr wraps mod 8", int'(rd), 2);
      brd(4'h2, rd); chk("R5 reset bit reads zero", int'(rd), 0);
      bwr(4'h2, 8'h10);
      brd(4'hD, rd); chk("R5 ptr cleared", int'(rd), 0);
      m_ptr = 0;
      for (int i = 0; i < 8; i++) begin
         brd(4'hC, rd); chk("R6 slot overwrite on wrap", int'(rd), int'(m_ring[i]));
         m_ptr = (m_ptr + 1) % 8;
      end
      run_txn(8'h9F, 0, 3, 1);   // R8 rx only
      run_txn(8'h03, 3, 4, 2);   // R2 R7
      run_txn(8'h0B, 8, 8, 3);   // R7 ring wrap
      run_txn(8'hAB, 15, 12, 4); // R3 clamp
      run_txn(8'h02, 2, 0, 5);   // R2 tx only
      run_txn(8'h05, 0, 8, 6);   // R8 full rx-only
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule